// File: doc/BRIEF.md
# Reservation Critical-Region Instruction Monitor

This block observes the retirement stream of a 32-bit RISC-V core and tracks the window between a load-reserved and the store-conditional that follows it. Inside that window it classifies every retired instruction. It flags any instruction that breaks the constrained-sequence rules. Those rules allow only plain integer work, forward control flow and a bounded instruction count. Because of them, a trap-and-emulate hypervisor never has to keep a reservation alive across a sensitive instruction.

The retirement stream is an observation port. It carries a valid strobe but no ready signal, because the monitor accepts one instruction in every cycle and can never stall the core. A cycle with the strobe low carries no instruction, and the monitor ignores it. The block has two outputs. The first is a registered region indicator. The second is a one-cycle violation pulse, which a reservation tracker can use to drop its reservation. The monitor does not execute instructions, does not hold the reservation, and does not decode compressed encodings.

Top module: `lrsc_region_checker`

## Requirements
- R1: After reset, `region_active` is 0 and `violation_pulse` is 0.
- R2: A retired load-reserved opens the region, and `region_active` reads 1 from the following cycle. A load-reserved has opcode 0101111, funct3 010, bits [31:27] = 00010 and rs2 = 0. A load-reserved that retires inside an open region restarts it, which clears the instruction count and the violated state.
- R3: A retired store-conditional closes an open region without raising a pulse. A store-conditional has opcode 0101111, funct3 010 and bits [31:27] = 00011. Outside a region, a store-conditional has no effect.
- R4: Inside the region, any instruction outside the base integer set is a violation. This covers opcode OP (0110011) with funct7 0000001 (multiply/divide) and any opcode that is not in the base integer set.
- R5: Inside the region, any load (opcode 0000011), store (0100011) or other atomic memory operation is a violation.
- R6: Inside the region, a JAL (1101111) whose target is not above its PC is a violation. A JALR (1100111) is always a violation.
- R7: Inside the region, a conditional branch (1100011) is a violation only when `ret_taken` is 1 and its target is not above its PC.
- R8: Inside the region, any MISC-MEM instruction (0001111; fence and instruction fence) and any SYSTEM instruction (1110011; CSR accesses, environment calls) is a violation.
- R9: The closing store-conditional is not counted. Any instruction that retires after the 16th instruction of the region is a violation.
- R10: A violation raises `violation_pulse` for exactly one cycle, the cycle after the offending retire edge. Later violations in the same region raise no further pulse.
- R11: Cycles with `ret_valid` low change neither output and do not advance the count. Outside a region, no instruction raises a pulse.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| ret_valid | input | 1 | An instruction retires this cycle |
| ret_insn | input | 32 | Retired instruction word |
| ret_pc | input | 32 | PC of the retired instruction |
| ret_taken | input | 1 | Retired branch was taken |
| region_active | output | 1 | A load-reserved region is open |
| violation_pulse | output | 1 | One-cycle flag of the first violation in the region |

## Verification
The hardest case to reach is the edge of the count limit. To get there, the stimulus must open a region and then feed exactly sixteen clean instructions with no violation before it, and the seventeenth must be the one that fires. The scenario that covers the idle strobe builds on this. It slips invalid cycles that carry a forbidden word into the middle of that run, so a count that wrongly advanced on idle cycles would fire one instruction early. Restart is reached by violating, reopening without a store-conditional, and then violating again, which must raise a second pulse.

// File: rtl/lrsc_chk_pkg.sv
package lrsc_chk_pkg;
  localparam logic [6:0] OPC_LUI    = 7'b0110111;
  localparam logic [6:0] OPC_AUIPC  = 7'b0010111;
  localparam logic [6:0] OPC_JAL    = 7'b1101111;
  localparam logic [6:0] OPC_JALR   = 7'b1100111;
  localparam logic [6:0] OPC_BRANCH = 7'b1100011;
  localparam logic [6:0] OPC_LOAD   = 7'b0000011;
  localparam logic [6:0] OPC_STORE  = 7'b0100011;
  localparam logic [6:0] OPC_OPIMM  = 7'b0010011;
  localparam logic [6:0] OPC_OP     = 7'b0110011;
  localparam logic [6:0] OPC_MISC   = 7'b0001111;
  localparam logic [6:0] OPC_SYSTEM = 7'b1110011;
  localparam logic [6:0] OPC_AMO    = 7'b0101111;

  localparam logic [4:0] AMO_F5_LR  = 5'b00010;
  localparam logic [4:0] AMO_F5_SC  = 5'b00011;
  localparam logic [2:0] AMO_WORD   = 3'b010;

  localparam logic [6:0] F7_BASE    = 7'b0000000;
  localparam logic [6:0] F7_ALT     = 7'b0100000;

  typedef struct packed {
    logic is_lr;
    logic is_sc;
    logic forbidden;
    logic is_jal;
    logic is_branch;
  } insn_class_t;
endpackage

// File: rtl/lrsc_insn_decode.sv
module lrsc_insn_decode
  import lrsc_chk_pkg::*;
(
  input  logic [31:0]  insn,
  output insn_class_t  cls
);
  logic [6:0] opc;
  logic [2:0] f3;
  logic [6:0] f7;
  logic [4:0] f5;
  logic [4:0] rs2;

  assign opc = insn[6:0];
  assign f3  = insn[14:12];
  assign f7  = insn[31:25];
  assign f5  = insn[31:27];
  assign rs2 = insn[24:20];

  always_comb begin
    cls = '0;
    unique case (opc)
      OPC_LUI, OPC_AUIPC: cls.forbidden = 1'b0;
      OPC_OPIMM: begin
        if (f3 == 3'b001)      cls.forbidden = (f7 != F7_BASE);
        else if (f3 == 3'b101) cls.forbidden = (f7 != F7_BASE) && (f7 != F7_ALT);
        else                   cls.forbidden = 1'b0;
      end
      OPC_OP: begin
        if (f7 == F7_BASE)     cls.forbidden = 1'b0;
        else if (f7 == F7_ALT) cls.forbidden = !((f3 == 3'b000) || (f3 == 3'b101));
        else                   cls.forbidden = 1'b1;
      end
      OPC_JAL:    cls.is_jal = 1'b1;
      OPC_BRANCH: begin
        if ((f3 == 3'b010) || (f3 == 3'b011)) cls.forbidden = 1'b1;
        else                                  cls.is_branch = 1'b1;
      end
      OPC_AMO: begin
        if ((f3 == AMO_WORD) && (f5 == AMO_F5_LR) && (rs2 == 5'd0)) cls.is_lr = 1'b1;
        else if ((f3 == AMO_WORD) && (f5 == AMO_F5_SC))             cls.is_sc = 1'b1;
        else                                                        cls.forbidden = 1'b1;
      end
      default: cls.forbidden = 1'b1;
    endcase
  end

  always_comb begin
    assert ($onehot0({cls.is_lr, cls.is_sc, cls.forbidden, cls.is_jal, cls.is_branch}))
      else $error("a_r4_class_exclusive: decoder classes overlap");
  end
endmodule

// File: rtl/lrsc_target_dir.sv
module lrsc_target_dir #(
  parameter int XLEN = 32
) (
  input  logic [XLEN-1:0] pc,
  input  logic [31:7]     imm_bits,
  input  logic            is_jal,
  input  logic            is_branch,
  input  logic            taken,
  output logic            ctl_bad
);
  logic [XLEN-1:0] j_off, b_off, off, target;
  logic            backward;

  assign j_off = {{(XLEN-21){imm_bits[31]}}, imm_bits[31], imm_bits[19:12],
                  imm_bits[20], imm_bits[30:21], 1'b0};
  assign b_off = {{(XLEN-13){imm_bits[31]}}, imm_bits[31], imm_bits[7],
                  imm_bits[30:25], imm_bits[11:8], 1'b0};
  assign off      = is_jal ? j_off : b_off;
  assign target   = pc + off;
  assign backward = (target <= pc);

  always_comb begin
    if (is_jal)         ctl_bad = backward;
    else if (is_branch) ctl_bad = taken && backward;
    else                ctl_bad = 1'b0;
  end

  always_comb begin
    assert (!(ctl_bad && !is_jal && !taken))
      else $error("a_r7_untaken_clean: untaken branch flagged");
  end
endmodule

// File: rtl/lrsc_region_tracker.sv
module lrsc_region_tracker
  import lrsc_chk_pkg::*;
#(
  parameter int MAX_INSNS = 16
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        valid,
  input  insn_class_t cls,
  input  logic        ctl_bad,
  output logic        active,
  output logic        pulse
);
  localparam int CNT_W = $clog2(MAX_INSNS + 2);
  localparam logic [CNT_W-1:0] CNT_SAT = CNT_W'(MAX_INSNS + 1);
  localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MAX_INSNS);

  logic [CNT_W-1:0] count, count_inc;
  logic             violated;
  logic             hit;

  assign count_inc = (count == CNT_SAT) ? CNT_SAT : count + 1'b1;
  assign hit = active && !cls.is_lr && !cls.is_sc &&
               (cls.forbidden || ctl_bad || (count_inc > CNT_MAX));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active   <= 1'b0;
      violated <= 1'b0;
      count    <= '0;
      pulse    <= 1'b0;
    end else begin
      pulse <= 1'b0;
      if (valid) begin
        if (cls.is_lr) begin
          active   <= 1'b1;
          violated <= 1'b0;
          count    <= '0;
        end else if (cls.is_sc) begin
          if (active) begin
            active   <= 1'b0;
            violated <= 1'b0;
            count    <= '0;
          end
        end else if (active) begin
          count <= count_inc;
          if (hit && !violated) begin
            violated <= 1'b1;
            pulse    <= 1'b1;
          end
        end
      end
    end
  end

  a_r10_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |=> !pulse);
  a_r11_pulse_in_region: assert property (@(posedge clk) disable iff (!rst_n)
    pulse |-> $past(active));
  a_r2_lr_opens: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls.is_lr) |=> (active && !violated && !pulse));
  a_r3_sc_closes: assert property (@(posedge clk) disable iff (!rst_n)
    (valid && cls.is_sc && active) |=> (!active && !pulse));
  a_r11_idle_stable: assert property (@(posedge clk) disable iff (!rst_n)
    !valid |=> ($stable(active) && $stable(count) && !pulse));

  always_comb begin
    assert (count <= CNT_SAT) else $error("a_r9_count_bound: count past saturation");
  end
endmodule

// File: rtl/lrsc_region_checker.sv
module lrsc_region_checker
  import lrsc_chk_pkg::*;
#(
  parameter int XLEN      = 32,
  parameter int MAX_INSNS = 16
) (
  input  logic            clk,
  input  logic            rst_n,
  input  logic            ret_valid,
  input  logic [31:0]     ret_insn,
  input  logic [XLEN-1:0] ret_pc,
  input  logic            ret_taken,
  output logic            region_active,
  output logic            violation_pulse
);
  insn_class_t cls;
  logic        ctl_bad;

  lrsc_insn_decode u_dec (
    .insn (ret_insn),
    .cls  (cls)
  );

  lrsc_target_dir #(.XLEN(XLEN)) u_dir (
    .pc        (ret_pc),
    .imm_bits  (ret_insn[31:7]),
    .is_jal    (cls.is_jal),
    .is_branch (cls.is_branch),
    .taken     (ret_taken),
    .ctl_bad   (ctl_bad)
  );

  lrsc_region_tracker #(.MAX_INSNS(MAX_INSNS)) u_trk (
    .clk     (clk),
    .rst_n   (rst_n),
    .valid   (ret_valid),
    .cls     (cls),
    .ctl_bad (ctl_bad),
    .active  (region_active),
    .pulse   (violation_pulse)
  );

  a_r1_reset_idle: assert property (@(posedge clk)
    !rst_n |=> (!region_active && !violation_pulse));
endmodule

// File: tb/tb_lrsc_region_checker.sv
module tb_lrsc_region_checker;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic ret_valid = 1'b0;
  logic [31:0] ret_insn = 32'h0;
  logic [31:0] ret_pc = 32'h0;
  logic ret_taken = 1'b0;
  logic region_active, violation_pulse;
  int n_chk = 0;
  int n_bad = 0;
  bit done = 0;

  always #5 clk = ~clk;

  lrsc_region_checker dut (
    .clk(clk), .rst_n(rst_n), .ret_valid(ret_valid), .ret_insn(ret_insn),
    .ret_pc(ret_pc), .ret_taken(ret_taken),
    .region_active(region_active), .violation_pulse(violation_pulse)
  );

  localparam logic [31:0] I_LR    = {5'b00010, 2'b00, 5'd0, 5'd10, 3'b010, 5'd11, 7'h2F};
  localparam logic [31:0] I_SC    = {5'b00011, 2'b00, 5'd12, 5'd10, 3'b010, 5'd13, 7'h2F};
  localparam logic [31:0] I_ADDI  = {12'd1, 5'd1, 3'b000, 5'd1, 7'h13};
  localparam logic [31:0] I_MUL   = {7'b0000001, 5'd2, 5'd1, 3'b000, 5'd3, 7'h33};
  localparam logic [31:0] I_LW    = {12'd0, 5'd1, 3'b010, 5'd2, 7'h03};
  localparam logic [31:0] I_SW    = {7'd0, 5'd2, 5'd1, 3'b010, 5'd0, 7'h23};
  localparam logic [31:0] I_AMOADD= {5'b00000, 2'b00, 5'd2, 5'd1, 3'b010, 5'd3, 7'h2F};
  localparam logic [31:0] I_JALR  = {12'd8, 5'd1, 3'b000, 5'd0, 7'h67};
  localparam logic [31:0] I_FENCE = 32'h0FF0000F;
  localparam logic [31:0] I_FENCI = 32'h0000100F;
  localparam logic [31:0] I_ECALL = 32'h00000073;
  localparam logic [31:0] I_CSR   = 32'hC0002573;

  function automatic logic [31:0] jal(input logic [20:0] o);
    return {o[20], o[10:1], o[11], o[19:12], 5'd0, 7'h6F};
  endfunction
  function automatic logic [31:0] beq(input logic [12:0] o);
    return {o[12], o[10:5], 5'd2, 5'd1, 3'b000, o[4:1], o[11], 7'h63};
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic retire(input logic [31:0] insn, input logic [31:0] pc, input logic tk);
    @(negedge clk);
    ret_valid = 1'b1; ret_insn = insn; ret_pc = pc; ret_taken = tk;
    @(negedge clk);
    ret_valid = 1'b0; ret_taken = 1'b0;
  endtask

  task automatic idle(input logic [31:0] insn);
    @(negedge clk);
    ret_valid = 1'b0; ret_insn = insn; ret_taken = 1'b1;
    @(negedge clk);
    ret_taken = 1'b0;
  endtask

  task automatic one_bad(input string tag, input logic [31:0] insn, input logic [31:0] pc, input logic tk);
    retire(I_LR, 32'h100, 0);
    retire(insn, pc, tk);
    chk(tag, violation_pulse, 1);
    retire(I_SC, 32'h108, 0);
    chk(tag, region_active, 0);
  endtask

  task automatic one_ok(input string tag, input logic [31:0] insn, input logic [31:0] pc, input logic tk);
    retire(I_LR, 32'h100, 0);
    retire(insn, pc, tk);
    chk(tag, violation_pulse, 0);
    retire(I_SC, 32'h108, 0);
  endtask

  task automatic t_reset;
    chk("R1 active", region_active, 0);
    chk("R1 pulse", violation_pulse, 0);
  endtask

  task automatic t_clean;
    retire(I_LR, 32'h100, 0);
    chk("R2 open", region_active, 1);
    chk("R2 no pulse", violation_pulse, 0);
    retire(I_ADDI, 32'h104, 0);
    chk("R2 addi ok", violation_pulse, 0);
    retire(I_SC, 32'h108, 0);
    chk("R3 close", region_active, 0);
    chk("R3 sc no pulse", violation_pulse, 0);
    retire(I_SC, 32'h10C, 0);
    chk("R3 stray sc", region_active, 0);
    chk("R3 stray sc pulse", violation_pulse, 0);
  endtask

  task automatic t_nonbase;
    retire(I_LR, 32'h100, 0);
    retire(I_MUL, 32'h104, 0);
    chk("R4 mul", violation_pulse, 1);
    @(negedge clk);
    chk("R10 pulse one cycle", violation_pulse, 0);
    retire(I_MUL, 32'h108, 0);
    chk("R10 second violation silent", violation_pulse, 0);
    chk("R10 still active", region_active, 1);
    retire(I_SC, 32'h10C, 0);
    chk("R3 close after violation", region_active, 0);
  endtask

  task automatic t_mem;
    one_bad("R5 load", I_LW, 32'h104, 0);
    one_bad("R5 store", I_SW, 32'h104, 0);
    one_bad("R5 amo", I_AMOADD, 32'h104, 0);
  endtask

  task automatic t_jumps;
    one_ok("R6 jal fwd", jal(21'd8), 32'h104, 0);
    one_bad("R6 jal back", jal(-21'sd8), 32'h104, 0);
    one_bad("R6 jal self", jal(21'd0), 32'h104, 0);
    one_bad("R6 jalr", I_JALR, 32'h104, 0);
  endtask

  task automatic t_branch;
    one_ok("R7 back not taken", beq(-13'sd16), 32'h200, 0);
    one_ok("R7 fwd taken", beq(13'd16), 32'h200, 1);
    one_bad("R7 back taken", beq(-13'sd16), 32'h200, 1);
  endtask

  task automatic t_sys;
    one_bad("R8 fence", I_FENCE, 32'h104, 0);
    one_bad("R8 fence.i", I_FENCI, 32'h104, 0);
    one_bad("R8 ecall", I_ECALL, 32'h104, 0);
    one_bad("R8 csr", I_CSR, 32'h104, 0);
  endtask

  task automatic t_count;
    retire(I_LR, 32'h100, 0);
    for (int i = 0; i < 16; i++) begin
      retire(I_ADDI, 32'h104 + 4*i, 0);
      chk("R9 within limit", violation_pulse, 0);
    end
    retire(I_ADDI, 32'h200, 0);
    chk("R9 17th", violation_pulse, 1);
    retire(I_SC, 32'h204, 0);
  endtask

  task automatic t_idle;
    retire(I_LR, 32'h100, 0);
    for (int i = 0; i < 15; i++) retire(I_ADDI, 32'h104 + 4*i, 0);
    idle(I_MUL);
    chk("R11 idle mul", violation_pulse, 0);
    idle(I_SC);
    chk("R11 idle sc", region_active, 1);
    retire(I_ADDI, 32'h140, 0);
    chk("R11 idle not counted", violation_pulse, 0);
    retire(I_ADDI, 32'h144, 0);
    chk("R9 limit after idle", violation_pulse, 1);
    retire(I_SC, 32'h148, 0);
    retire(I_MUL, 32'h14C, 0);
    chk("R11 outside region", violation_pulse, 0);
    chk("R11 outside inactive", region_active, 0);
  endtask

  task automatic t_restart;
    retire(I_LR, 32'h100, 0);
    retire(I_MUL, 32'h104, 0);
    chk("R2 first violation", violation_pulse, 1);
    retire(I_LR, 32'h108, 0);
    chk("R2 restart active", region_active, 1);
    chk("R2 restart no pulse", violation_pulse, 0);
    retire(I_MUL, 32'h10C, 0);
    chk("R2 restart re-arms", violation_pulse, 1);
    retire(I_LR, 32'h110, 0);
    for (int i = 0; i < 16; i++) retire(I_ADDI, 32'h114 + 4*i, 0);
    chk("R2 restart clears count", violation_pulse, 0);
    retire(I_SC, 32'h300, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_clean;
    t_nonbase;
    t_mem;
    t_jumps;
    t_branch;
    t_sys;
    t_count;
    t_idle;
    t_restart;
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual hung expected finished");
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
    end
  end
endmodule